// File: doc/BRIEF.md
# Serial Data Shifting Engine

This block carries out one already-decoded data-shifting command. It produces a serial clock from a clock-enable tick and moves data in three ways: it shifts an outgoing byte stream onto a data-out pin, it shifts the same stream onto a mode-select pin, and it samples a data-in pin back into bytes. Seven opcode flag bits pick the behaviour independently: the clock edge that launches data, the clock edge that samples, whole bytes or a short run of bits, bit order, and which of the three pins take part. One datapath therefore covers the whole family of shift commands.

A command is offered with `cmd_valid` while `busy` is low. The engine walks a four-state machine. IDLE holds the clock at the requested rest level and moves to LOAD on an accepted command. LOAD waits for one outgoing byte when a write pin is enabled, otherwise it passes straight through, and then goes to LEAD. LEAD makes the edge away from the rest level on the next tick and goes to TRAIL. TRAIL makes the edge back to the rest level on the next tick. It then goes to LEAD for the next bit, to LOAD for the next byte, or to IDLE after the last bit. Each edge whose direction matches the write flag launches the next bit, and each edge whose direction matches the read flag samples `din` as it stands just before that edge.

Top module: `serial_shift_engine`

## Requirements
- R1: After reset `sclk`, `dout`, `tms`, `busy`, `rx_valid` and `tx_ready` are all low.
- R2: A command whose opcode bit 7 is 1 is ignored. A `cmd_valid` pulse while `busy` is high is ignored. Neither produces any clock edge.
- R3: While idle, `sclk` follows `idle_high` and rests at that level. During a command every clock edge happens on a cycle with `tick` high, the first edge of each bit moves away from the rest level, and the clock ends at the rest level.
- R4: Opcode bit 0 picks the launch edge (0 = rising, 1 = falling). `dout` and `tms` change only on launch edges, and bit k appears on the k-th launch edge.
- R5: Opcode bit 2 picks the sampling edge (0 = rising, 1 = falling). `din` is taken in the cycle whose clock tick produces that edge.
- R6: Opcode bit 1 = 0 is byte mode: a length L moves L+1 bytes, which gives 16·(L+1) clock edges. Bit 1 = 1 is bit mode: (L mod 8)+1 bits are moved from one byte, and the upper length bits are ignored.
- R7: Opcode bit 3 picks the order on `dout`: 0 sends bit 7 of each byte first, 1 sends bit 0 first.
- R8: Opcode bit 4 enables `dout` and bit 6 enables `tms`. `tms` always sends bit 0 first. A pin that is not enabled keeps its value for the whole command.
- R9: Opcode bit 5 enables reading. It returns one `rx_valid` pulse per byte in byte mode and a single pulse in bit mode, with the captured bits right-justified (first bit in bit 0 when LSB-first, last bit in bit 0 when MSB-first). With bit 5 clear, `rx_valid` stays low.
- R10: One byte is taken through `tx_valid`/`tx_ready` per outgoing byte (one in bit mode), and none when both write pins are disabled. The clock halts at the rest level while a needed byte is missing.
- R11: `busy` rises the cycle after acceptance and falls together with the final clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock-enable; one serial-clock edge per tick |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_opcode | input | 8 | Opcode; bits 0–6 are flags, bit 7 must be 0 |
| cmd_length | input | LW | Count minus one (bytes or bits) |
| idle_high | input | 1 | Rest level of the serial clock |
| tx_data | input | DW | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Engine takes the outgoing byte |
| din | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| dout | output | 1 | Serial data out |
| tms | output | 1 | Mode-select serial out |
| rx_data | output | DW | Captured byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | Command in progress |

## Verification
The bench uses the default DW = 8 and LW = 16. With these values every opcode flag combination in the command family is reachable, bit mode covers its full 1-to-8 bit range, and byte mode runs up to four bytes, which crosses the byte-to-byte refetch in LOAD. Byte counts near the 65536 limit are not reached. The bench also slows `tick` to one in four cycles and holds back `tx_valid`, which exercises the halted-clock path.

// File: rtl/sse_pkg.sv
package sse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_LEAD  = 2'd2,
        ST_TRAIL = 2'd3
    } sse_state_e;

    // Field order follows the opcode bit positions 6..0
    typedef struct packed {
        logic tms_en;     // bit 6
        logic rd_en;      // bit 5
        logic wr_en;      // bit 4
        logic lsb_first;  // bit 3
        logic rd_fall;    // bit 2
        logic bit_mode;   // bit 1
        logic wr_fall;    // bit 0
    } sse_flags_t;

    function automatic sse_flags_t sse_decode(input logic [7:0] op);
        sse_flags_t f;
        f = sse_flags_t'(op[6:0]);
        return f;
    endfunction

    function automatic logic sse_is_shift(input logic [7:0] op);
        return ~op[7];
    endfunction

endpackage

// File: rtl/sse_ctl.sv
module sse_ctl
    import sse_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          cmd_valid,
    input  logic [7:0]                    cmd_opcode,
    input  logic [LW-1:0]                 cmd_length,
    input  logic                          idle_high,
    input  logic                          tx_valid,
    output logic                          tx_ready,
    output logic                          sclk,
    output logic                          busy,
    output sse_flags_t                    flags,
    output logic [((DW>1)?$clog2(DW):1)-1:0] bit_idx,
    output logic [((DW>1)?$clog2(DW):1)-1:0] nbits_m1,
    output logic                          load_o,
    output logic                          launch_o,
    output logic                          sample_o,
    output logic                          emit_o
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

    sse_state_e      state_q, state_d;
    sse_flags_t      flags_q;
    logic            idle_q;
    logic            sclk_q;
    logic [IW-1:0]   bit_idx_q;
    logic [IW-1:0]   nbits_m1_q;
    logic [LW-1:0]   bytes_left_q;

    logic            accept;
    logic            needs_tx;
    logic            edge_go;
    logic            edge_is_fall;
    logic            last_bit;
    logic            last_byte;

    assign accept    = (state_q == ST_IDLE) && cmd_valid && sse_is_shift(cmd_opcode);
    assign needs_tx  = flags_q.wr_en | flags_q.tms_en;
    assign last_bit  = (bit_idx_q == nbits_m1_q);
    assign last_byte = (bytes_left_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (!needs_tx || tx_valid) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) state_d = ST_TRAIL;
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (!last_bit)      state_d = ST_LEAD;
                    else if (last_byte) state_d = ST_IDLE;
                    else                state_d = ST_LOAD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Edge strobes
    always_comb begin
        edge_go      = ((state_q == ST_LEAD) || (state_q == ST_TRAIL)) && tick;
        edge_is_fall = (state_q == ST_LEAD) ? idle_q : ~idle_q;
        launch_o     = edge_go && (edge_is_fall == flags_q.wr_fall);
        sample_o     = edge_go && flags_q.rd_en && (edge_is_fall == flags_q.rd_fall);
        emit_o       = (state_q == ST_TRAIL) && tick && last_bit && flags_q.rd_en;
        tx_ready     = (state_q == ST_LOAD) && needs_tx;
        load_o       = tx_ready && tx_valid;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q      <= '0;
            idle_q       <= 1'b0;
            sclk_q       <= 1'b0;
            bit_idx_q    <= '0;
            nbits_m1_q   <= '0;
            bytes_left_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sclk_q <= idle_high;
                    if (accept) begin
                        flags_q   <= sse_decode(cmd_opcode);
                        idle_q    <= idle_high;
                        bit_idx_q <= '0;
                        if (cmd_opcode[1]) begin
                            nbits_m1_q   <= cmd_length[IW-1:0];
                            bytes_left_q <= '0;
                        end else begin
                            nbits_m1_q   <= LAST_IDX;
                            bytes_left_q <= cmd_length;
                        end
                    end
                end
                ST_LOAD: begin
                    sclk_q <= idle_q;
                end
                ST_LEAD: begin
                    if (tick) sclk_q <= ~idle_q;
                end
                ST_TRAIL: begin
                    if (tick) begin
                        sclk_q <= idle_q;
                        if (last_bit) begin
                            bit_idx_q <= '0;
                            if (!last_byte) bytes_left_q <= bytes_left_q - 1'b1;
                        end else begin
                            bit_idx_q <= bit_idx_q + 1'b1;
                        end
                    end
                end
                default: sclk_q <= idle_q;
            endcase
        end
    end

    assign sclk     = sclk_q;
    assign busy     = (state_q != ST_IDLE);
    assign flags    = flags_q;
    assign bit_idx  = bit_idx_q;
    assign nbits_m1 = nbits_m1_q;

    // R3: clock edges only on enabled ticks while a command runs
    p_sclk_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_q) != ST_IDLE) && !$stable(sclk_q)) |-> $past(tick));

    // R2: configuration of a running command cannot be replaced
    p_no_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(flags_q));

    // R10: a byte is only taken while waiting in LOAD
    p_load_in_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (state_q == ST_LEAD));

endmodule

// File: rtl/sse_tx.sv
module sse_tx #(
    parameter int DW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [DW-1:0]                 load_data,
    input  logic                          launch,
    input  logic [((DW>1)?$clog2(DW):1)-1:0] bit_idx,
    input  logic                          wr_en,
    input  logic                          tms_en,
    input  logic                          lsb_first,
    output logic                          dout,
    output logic                          tms
);
    logic [DW-1:0] byte_q;
    logic [DW-1:0] byte_rev;
    logic          data_bit;

    // Mirrored copy so both orders use the same index
    for (genvar g = 0; g < DW; g++) begin : g_mirror
        assign byte_rev[g] = byte_q[DW-1-g];
    end

    assign data_bit = lsb_first ? byte_q[bit_idx] : byte_rev[bit_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            dout   <= 1'b0;
            tms    <= 1'b0;
        end else begin
            if (load) byte_q <= load_data;
            if (launch && wr_en)  dout <= data_bit;
            if (launch && tms_en) tms  <= byte_q[bit_idx];
        end
    end

endmodule

// File: rtl/sse_rx.sv
module sse_rx #(
    parameter int DW = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sample,
    input  logic                          din,
    input  logic                          emit,
    input  logic                          lsb_first,
    input  logic [((DW>1)?$clog2(DW):1)-1:0] nbits_m1,
    output logic [DW-1:0]                 rx_data,
    output logic                          rx_valid
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DW - 1);

    logic [DW-1:0] cap_q;
    logic [DW-1:0] cap_next;
    logic [IW-1:0] justify_sh;

    always_comb begin
        cap_next = cap_q;
        if (sample) begin
            if (lsb_first) cap_next = {din, cap_q[DW-1:1]};
            else           cap_next = {cap_q[DW-2:0], din};
        end
        justify_sh = LAST_IDX - nbits_m1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else if (emit) begin
            rx_data  <= lsb_first ? (cap_next >> justify_sh) : cap_next;
            rx_valid <= 1'b1;
            cap_q    <= '0;
        end else begin
            rx_valid <= 1'b0;
            cap_q    <= cap_next;
        end
    end

    // R9: one strobe per finished byte, never back to back
    p_rx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/serial_shift_engine.sv
module serial_shift_engine
    import sse_pkg::*;
#(
    parameter int DW = 8,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_opcode,
    input  logic [LW-1:0] cmd_length,
    input  logic          idle_high,
    input  logic [DW-1:0] tx_data,
    input  logic          tx_valid,
    output logic          tx_ready,
    input  logic          din,
    output logic          sclk,
    output logic          dout,
    output logic          tms,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          busy
);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;

    sse_flags_t    flags;
    logic [IW-1:0] bit_idx;
    logic [IW-1:0] nbits_m1;
    logic          load_s, launch_s, sample_s, emit_s;

    sse_ctl #(.DW(DW), .LW(LW)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmd_valid  (cmd_valid),
        .cmd_opcode (cmd_opcode),
        .cmd_length (cmd_length),
        .idle_high  (idle_high),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .sclk       (sclk),
        .busy       (busy),
        .flags      (flags),
        .bit_idx    (bit_idx),
        .nbits_m1   (nbits_m1),
        .load_o     (load_s),
        .launch_o   (launch_s),
        .sample_o   (sample_s),
        .emit_o     (emit_s)
    );

    sse_tx #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_s),
        .load_data (tx_data),
        .launch    (launch_s),
        .bit_idx   (bit_idx),
        .wr_en     (flags.wr_en),
        .tms_en    (flags.tms_en),
        .lsb_first (flags.lsb_first),
        .dout      (dout),
        .tms       (tms)
    );

    sse_rx #(.DW(DW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample_s),
        .din       (din),
        .emit      (emit_s),
        .lsb_first (flags.lsb_first),
        .nbits_m1  (nbits_m1),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    // R4: data-out moves only together with a clock edge
    p_dout_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> !$stable(sclk));

    // R8: mode-select moves only together with a clock edge
    p_tms_on_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> !$stable(sclk));

endmodule

// File: tb/sim_serial_shift_engine.sv
`timescale 1ns/1ps
module sim_serial_shift_engine;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] len;
        logic        idle;
        logic [31:0] txw;
        logic [31:0] pat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h10, 16'h0000, 1'b0, 32'h000000A5, 32'h00000000},
        '{8'h19, 16'h0001, 1'b1, 32'h0000C33C, 32'h00000000},
        '{8'h13, 16'h0104, 1'b1, 32'h000000B6, 32'h00000000},
        '{8'h20, 16'h0000, 1'b0, 32'h00000000, 32'h000000B1},
        '{8'h2C, 16'h0001, 1'b0, 32'h00000000, 32'h0000E14D},
        '{8'h31, 16'h0001, 1'b1, 32'h00009E47, 32'h000062D5},
        '{8'h3E, 16'h0002, 1'b0, 32'h00000005, 32'h00000006},
        '{8'h4B, 16'h0006, 1'b1, 32'h00000035, 32'h00000000},
        '{8'h6A, 16'h0003, 1'b0, 32'h0000000A, 32'h00000009},
        '{8'h2A, 16'h0007, 1'b0, 32'h00000000, 32'h000000C3},
        '{8'h3B, 16'h0005, 1'b1, 32'h0000002D, 32'h00000015},
        '{8'h11, 16'h0003, 1'b1, 32'h8001FF7E, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = '0;
    logic [15:0] cmd_length = '0;
    logic        idle_high = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        din = 1'b0;
    logic        sclk, dout, tms, rx_valid, busy;
    logic [7:0]  rx_data;

    int tests = 0, failed = 0;
    bit done = 0;

    // monitor state
    bit          rec_en = 0;
    logic [7:0]  cur_op = '0;
    logic [31:0] cur_pat = '0;
    logic [31:0] cur_txw = '0;
    logic        sclk_d = 0, busy_d = 0, dout_d = 0, tms_d = 0, tick_d = 1;
    int          n_edges = 0, n_wr = 0, n_rd = 0, n_rx = 0, tick_viol = 0, busy_cyc = 0;
    logic [31:0] dout_seq = '0, tms_seq = '0;
    bit          dout_moved = 0, tms_moved = 0;
    logic [7:0]  rx_got [4];
    // feeder state
    int          tx_idx = 0, tx_cnt = 0, hold = 0;
    bit          take_pend = 0;
    bit          tick_slow = 0;
    int          tick_cnt = 0;

    serial_shift_engine #(.DW(8), .LW(16)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_opcode(cmd_opcode), .cmd_length(cmd_length), .idle_high(idle_high),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .din(din),
        .sclk(sclk), .dout(dout), .tms(tms), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // tick generator
    initial begin
        forever begin
            @(posedge clk); #1;
            if (tick_slow) begin
                tick_cnt = (tick_cnt + 1) % 4;
                tick = (tick_cnt == 0);
            end else begin
                tick = 1'b1;
            end
        end
    end

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rec_en && (busy || busy_d)) begin
                if (busy) busy_cyc++;
                if (sclk !== sclk_d) begin
                    n_edges++;
                    if (!tick_d) tick_viol++;
                    if ((sclk == 1'b0) == cur_op[0]) begin
                        if (n_wr < 32) begin
                            dout_seq[n_wr] = dout;
                            tms_seq[n_wr]  = tms;
                        end
                        n_wr++;
                    end
                    if ((sclk == 1'b0) == cur_op[2]) begin
                        n_rd++;
                        din = (n_rd < 32) ? cur_pat[n_rd] : 1'b0;
                    end
                end
                if (dout !== dout_d) dout_moved = 1;
                if (tms !== tms_d) tms_moved = 1;
            end
            if (rx_valid) begin
                if (n_rx < 4) rx_got[n_rx] = rx_data;
                n_rx++;
            end
            sclk_d = sclk; busy_d = busy; dout_d = dout; tms_d = tms; tick_d = tick;
        end
    end

    // outgoing byte feeder
    initial begin
        forever begin
            @(negedge clk);
            if (take_pend) tx_idx++;
            if (hold > 0) begin
                hold--;
                tx_valid = 1'b0;
            end else begin
                tx_valid = (tx_idx < tx_cnt);
            end
            tx_data = (tx_idx < 4) ? cur_txw[tx_idx*8 +: 8] : 8'h00;
            take_pend = tx_valid && tx_ready;
        end
    end

    task automatic run_cmd(input vec_t v, input int hold_cyc, input bit intrude);
        @(negedge clk); #1;
        idle_high = v.idle;
        repeat (2) @(negedge clk);
        #1;
        n_edges = 0; n_wr = 0; n_rd = 0; n_rx = 0; tick_viol = 0; busy_cyc = 0;
        dout_seq = '0; tms_seq = '0; dout_moved = 0; tms_moved = 0;
        cur_op = v.op; cur_pat = v.pat; cur_txw = v.txw;
        din = v.pat[0];
        tx_idx = 0; take_pend = 0; hold = hold_cyc;
        tx_cnt = (v.op[4] || v.op[6]) ? (v.op[1] ? 1 : int'(v.len) + 1) : 0;
        rec_en = 1;
        cmd_opcode = v.op; cmd_length = v.len; cmd_valid = 1'b1;
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            #1;
            cmd_opcode = 8'h10; cmd_length = 16'h0003; cmd_valid = 1'b1;
            @(negedge clk); #1;
            cmd_valid = 1'b0;
        end
        for (int c = 0; c < 4000 && busy; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
        rec_en = 0;
    endtask

    task automatic check_vec(input vec_t v, input string tag);
        int nb, nby, bits;
        logic [31:0] exp_d, exp_t;
        logic [7:0] b, r;
        nb  = v.op[1] ? (int'(v.len[2:0]) + 1) : (int'(v.len) + 1) * 8;
        nby = v.op[1] ? 1 : int'(v.len) + 1;
        exp_d = '0; exp_t = '0;
        for (int k = 0; k < nb; k++) begin
            b = v.txw[(k/8)*8 +: 8];
            exp_d[k] = v.op[3] ? b[k%8] : b[7-(k%8)];
            exp_t[k] = b[k%8];
        end
        chk(n_edges == 2*nb, {tag, " R6 edge count"}, n_edges, 2*nb);
        chk(tick_viol == 0 && sclk == v.idle, {tag, " R3 ticks/rest level"}, {tick_viol[30:0], sclk}, {31'd0, v.idle});
        if (v.op[4])
            chk(dout_seq == exp_d, {tag, " R4 R7 dout bits"}, dout_seq, exp_d);
        else
            chk(!dout_moved, {tag, " R8 dout held"}, 32'(dout_moved), 32'd0);
        if (v.op[6])
            chk(tms_seq == exp_t, {tag, " R8 tms bits"}, tms_seq, exp_t);
        else
            chk(!tms_moved, {tag, " R8 tms held"}, 32'(tms_moved), 32'd0);
        if (v.op[5]) begin
            chk(n_rx == nby, {tag, " R9 rx count"}, n_rx, nby);
            for (int j = 0; j < nby && j < 4; j++) begin
                bits = v.op[1] ? nb : 8;
                r = '0;
                for (int i = 0; i < bits; i++) begin
                    if (v.op[3]) r[i] = v.pat[j*8+i];
                    else         r = {r[6:0], v.pat[j*8+i]};
                end
                chk(rx_got[j] == r, {tag, " R5 R9 rx byte"}, rx_got[j], r);
            end
        end else begin
            chk(n_rx == 0, {tag, " R9 no rx"}, n_rx, 0);
        end
        chk(tx_idx == tx_cnt, {tag, " R10 bytes taken"}, tx_idx, tx_cnt);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            tests++; failed++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk({sclk, dout, tms, busy, rx_valid, tx_ready} == 6'b0, "R1 reset outputs",
            {26'd0, sclk, dout, tms, busy, rx_valid, tx_ready}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({sclk, dout, tms, busy, rx_valid, tx_ready} == 6'b0, "R1 after release",
            {26'd0, sclk, dout, tms, busy, rx_valid, tx_ready}, 32'd0);

        // table walk
        for (int n = 0; n < NV; n++) begin
            run_cmd(VECS[n], 0, 0);
            check_vec(VECS[n], $sformatf("vec%0d", n));
        end

        // R3 rest level follows idle_high while idle
        @(negedge clk); #1 idle_high = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R3 idle follows high", 32'(sclk), 32'd1);
        #1 idle_high = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R3 idle follows low", 32'(sclk), 32'd0);

        // R2 bit 7 set: ignored
        v = '{8'h90, 16'h0001, 1'b0, 32'h0, 32'h0};
        run_cmd(v, 0, 0);
        chk(n_edges == 0 && busy_cyc == 0, "R2 bit7 ignored", {n_edges[15:0], busy_cyc[15:0]}, 32'd0);

        // R2 command while busy ignored
        v = '{8'h12, 16'h0002, 1'b0, 32'h000000E0, 32'h0};
        run_cmd(v, 0, 1);
        chk(n_edges == 6, "R2 busy intrusion ignored", n_edges, 6);
        chk(dout_seq[2:0] == 3'b111, "R2 R7 data of first command", {29'd0, dout_seq[2:0]}, 32'd7);

        // R3 slow tick
        tick_slow = 1;
        v = '{8'h10, 16'h0000, 1'b0, 32'h0000005C, 32'h0};
        run_cmd(v, 0, 0);
        tick_slow = 0;
        check_vec(v, "slowtick");
        chk(busy_cyc >= 60, "R3 slow tick duration", busy_cyc, 60);

        // R10/R11 stalled outgoing byte
        v = '{8'h18, 16'h0001, 1'b0, 32'h000081A3, 32'h0};
        run_cmd(v, 20, 0);
        check_vec(v, "stall");
        chk(busy_cyc >= 52, "R10 R11 clock halts while waiting", busy_cyc, 52);

        done = 1;
        summary();
        $finish;
    end

endmodule